// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block gathers sector erase requests for a flash array into a one-hot-per-sector mask and then launches them together as a single concurrent erase. The first sector erase command opens a timed acceptance window. Each further sector erase command adds its sector to the mask and restarts the window. The start of any new write strobe also restarts the window. When the window runs out with no new activity, the block emits a one-cycle erase-start pulse. It then holds the mask for a busy period of fixed length and clears the mask at the end of that period.

A command other than sector erase that arrives while the window is open cancels the pending set, with no erase launched. The window length and the busy length are parameters counted in clock cycles. The sector is taken from the top address bits. The window-open output lets a host poll whether more sectors can still be queued. All inputs are single-cycle control pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sector_erase_accum`

## Requirements
- R1: After reset, `sector_mask` is 0, `window_open` is 0 and `erase_start` is 0.
- R2: The sector index is `se_addr[16:14]`. A sector erase command to sector n sets bit n of `sector_mask`, with bit 0 for sector 0 and bit 7 for sector 7.
- R3: A `se_cmd` pulse while idle raises `window_open` and sets the sector bit, both visible in the cycle after the pulse.
- R4: A `se_cmd` while the window is open ORs its sector into the mask. Order does not matter, and repeating a sector leaves the mask unchanged.
- R5: If no `se_cmd`, `wr_start` or `other_cmd` occurs for WINDOW_CYC cycles after the last restart, then in the next cycle `window_open` falls and `erase_start` is 1, with the mask kept.
- R6: A `wr_start` or `se_cmd` while the window is open restarts the full window, even in the cycle the window would otherwise have expired.
- R7: An `other_cmd` while the window is open clears the mask and closes the window without `erase_start`. It wins over a `se_cmd` in the same cycle.
- R8: While idle, `other_cmd` and `wr_start` have no effect: the mask stays 0 and the window stays closed.
- R9: For ERASE_CYC cycles from `erase_start`, every input is ignored and the mask is held. At the end of that period the mask is cleared and the block is idle.
- R10: `erase_start` is high for exactly one cycle per launched erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se_cmd | input | 1 | Sector erase command accepted (pulse) |
| se_addr | input | 17 | Address that goes with `se_cmd` |
| other_cmd | input | 1 | Any other command accepted (pulse) |
| wr_start | input | 1 | A new write strobe has begun (pulse) |
| sector_mask | output | 8 | Sectors queued or being erased |
| erase_start | output | 1 | One-cycle launch pulse |
| window_open | output | 1 | Acceptance window is open |

## Verification
Two functions can collide in the same cycle. The first is a window restart landing in the very cycle of expiry: a directed case places `wr_start` on the final window cycle, and the check requires the window to stay open with no launch. The second is an abort together with a sector command: the check requires the mask to be empty and the window closed. Random pulse mixes also produce both collisions. A cycle-level reference model in the bench judges every cycle's outputs.

// File: rtl/sea_pkg.sv
package sea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sea_state_e;
endpackage

// File: rtl/sea_sector_dec.sv
module sea_sector_dec #(
  parameter int ADDR_W   = 17,
  parameter int SEC_BITS = 3,
  localparam int N_SEC   = 1 << SEC_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SEC-1:0]  onehot
);
  logic [SEC_BITS-1:0] idx;
  assign idx = addr[ADDR_W-1 -: SEC_BITS];

  for (genvar g = 0; g < N_SEC; g++) begin : g_bit
    assign onehot[g] = (idx == SEC_BITS'(g));
  end
endmodule

// File: rtl/sea_count.sv
module sea_count #(
  parameter int LIMIT = 16,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run)        cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sector_erase_accum.sv
module sector_erase_accum #(
  parameter int ADDR_W     = 17,
  parameter int SEC_BITS   = 3,
  parameter int WINDOW_CYC = 20000,
  parameter int ERASE_CYC  = 64,
  localparam int N_SEC     = 1 << SEC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se_cmd,
  input  logic [ADDR_W-1:0] se_addr,
  input  logic              other_cmd,
  input  logic              wr_start,
  output logic [N_SEC-1:0]  sector_mask,
  output logic              erase_start,
  output logic              window_open
);
  import sea_pkg::*;

  sea_state_e       state;
  logic [N_SEC-1:0] sel;
  logic             restart;
  logic             win_last;
  logic             ers_last;
  logic             in_window;
  logic             erasing;

  assign in_window = (state == ST_WINDOW);
  assign erasing   = (state == ST_ERASE);
  assign restart   = se_cmd | wr_start;

  sea_sector_dec #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS)) u_dec (
    .addr   (se_addr),
    .onehot (sel)
  );

  sea_count #(.LIMIT(WINDOW_CYC)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_window || restart),
    .run   (in_window),
    .last  (win_last)
  );

  sea_count #(.LIMIT(ERASE_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!erasing),
    .run   (erasing),
    .last  (ers_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sector_mask <= '0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (se_cmd) begin
            sector_mask <= sel;
            state       <= ST_WINDOW;
          end
        end
        ST_WINDOW: begin
          if (other_cmd) begin
            sector_mask <= '0;
            state       <= ST_IDLE;
          end else if (se_cmd) begin
            sector_mask <= sector_mask | sel;
          end else if (!wr_start && win_last) begin
            state       <= ST_ERASE;
            erase_start <= 1'b1;
          end
        end
        ST_ERASE: begin
          if (ers_last) begin
            sector_mask <= '0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign window_open = in_window;
endmodule

// File: rtl/sea_chk.sv
module sea_chk #(
  parameter int N_SEC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             se_cmd,
  input logic             other_cmd,
  input logic [N_SEC-1:0] sector_mask,
  input logic             erase_start,
  input logic             window_open,
  input logic             erasing
);
  // R3
  open_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erasing && se_cmd) |=> window_open);

  // R4
  mask_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && !other_cmd) |=> ((sector_mask & $past(sector_mask)) == $past(sector_mask)));

  // R5
  launch_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (!window_open && $past(window_open) && sector_mask != '0));

  // R7
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && other_cmd) |=> (sector_mask == '0 && !window_open && !erase_start));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erasing && !se_cmd) |=> (!window_open && sector_mask == '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing)) |-> $stable(sector_mask));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
endmodule

bind sector_erase_accum sea_chk #(.N_SEC(N_SEC)) u_sea_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .se_cmd      (se_cmd),
  .other_cmd   (other_cmd),
  .sector_mask (sector_mask),
  .erase_start (erase_start),
  .window_open (window_open),
  .erasing     (erasing)
);

// File: tb/sector_erase_accum_bench.sv
`timescale 1ns/1ps
module sector_erase_accum_bench;
  localparam int W = 12;
  localparam int E = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        se_cmd = 1'b0;
  logic [16:0] se_addr = '0;
  logic        other_cmd = 1'b0;
  logic        wr_start = 1'b0;
  logic [7:0]  sector_mask;
  logic        erase_start;
  logic        window_open;

  int n_chk = 0;
  int n_fail = 0;

  int       m_st = 0;
  logic [7:0] m_mask = '0;
  int       m_cnt = 0;
  int       m_b = 0;
  logic     m_start = 1'b0;

  always #2 clk = ~clk;

  sector_erase_accum #(.WINDOW_CYC(W), .ERASE_CYC(E)) u_sector_erase_accum (
    .clk, .rst_n, .se_cmd, .se_addr, .other_cmd, .wr_start,
    .sector_mask, .erase_start, .window_open
  );

  function automatic logic [7:0] sec_bit(input logic [16:0] a);
    return 8'b1 << a[16:14];
  endfunction

  function automatic logic [16:0] sec_addr(input int s, input int low);
    return {s[2:0], low[13:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic se, input logic [16:0] a, input logic oth, input logic ws);
    m_start = 1'b0;
    case (m_st)
      0: if (se) begin m_mask = sec_bit(a); m_st = 1; m_cnt = 0; end
      1: begin
        if (oth) begin m_mask = '0; m_st = 0; end
        else if (se) begin m_mask = m_mask | sec_bit(a); m_cnt = 0; end
        else if (ws) m_cnt = 0;
        else if (m_cnt == W - 1) begin m_st = 2; m_start = 1'b1; m_b = 0; end
        else m_cnt++;
      end
      default: begin
        if (m_b == E - 1) begin m_st = 0; m_mask = '0; end
        else m_b++;
      end
    endcase
  endtask

  task automatic tick(input logic se, input logic [16:0] a, input logic oth, input logic ws);
    se_cmd = se; se_addr = a; other_cmd = oth; wr_start = ws;
    @(posedge clk);
    model(se, a, oth, ws);
    @(negedge clk);
    se_cmd = 1'b0; other_cmd = 1'b0; wr_start = 1'b0;
    chk("R4 model mask", 32'(sector_mask), 32'(m_mask));
    chk("R5 model erase_start", 32'(erase_start), 32'(m_start));
    chk("R5 model window_open", 32'(window_open), 32'(m_st == 1));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mask", 32'(sector_mask), 0);
    chk("R1 window", 32'(window_open), 0);
    chk("R1 start", 32'(erase_start), 0);
    rst_n = 1'b1;
    idle(1);
    // R8: foreign command and strobe while idle
    tick(1'b0, '0, 1'b1, 1'b0);
    tick(1'b0, '0, 1'b0, 1'b1);
    chk("R8 mask", 32'(sector_mask), 0);
    chk("R8 window", 32'(window_open), 0);
    // R2 / R3: first command to sector 5
    tick(1'b1, sec_addr(5, 123), 1'b0, 1'b0);
    chk("R2 mask", 32'(sector_mask), 32'h20);
    chk("R3 window", 32'(window_open), 1);
    // R4: add sector 2, repeat sector 5
    tick(1'b1, sec_addr(2, 7), 1'b0, 1'b0);
    chk("R4 add", 32'(sector_mask), 32'h24);
    tick(1'b1, sec_addr(5, 9), 1'b0, 1'b0);
    chk("R4 dup", 32'(sector_mask), 32'h24);
    // R6: restart on the expiry cycle
    idle(W - 1);
    tick(1'b0, '0, 1'b0, 1'b1);
    chk("R6 window", 32'(window_open), 1);
    chk("R6 start", 32'(erase_start), 0);
    // R5: expiry after a full quiet window
    idle(W - 1);
    chk("R5 still open", 32'(window_open), 1);
    idle(1);
    chk("R5 start", 32'(erase_start), 1);
    chk("R5 closed", 32'(window_open), 0);
    chk("R5 mask", 32'(sector_mask), 32'h24);
    idle(1);
    chk("R10 pulse", 32'(erase_start), 0);
    // R9: ignored during the busy period
    tick(1'b1, sec_addr(0, 1), 1'b1, 1'b1);
    chk("R9 ignore", 32'(sector_mask), 32'h24);
    chk("R9 window", 32'(window_open), 0);
    idle(E - 3);
    chk("R9 held", 32'(sector_mask), 32'h24);
    idle(1);
    chk("R9 cleared", 32'(sector_mask), 0);
    // R7: abort together with a sector command
    tick(1'b1, sec_addr(7, 0), 1'b0, 1'b0);
    chk("R7 setup", 32'(sector_mask), 32'h80);
    tick(1'b1, sec_addr(1, 0), 1'b1, 1'b0);
    chk("R7 mask", 32'(sector_mask), 0);
    chk("R7 window", 32'(window_open), 0);
    idle(W + 2);
    chk("R7 no launch", 32'(erase_start), 0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic se, oth, ws;
      r = $urandom_range(99);
      se = (r < 10);
      oth = (r >= 10 && r < 12);
      ws = ($urandom_range(99) < 7);
      tick(se, 17'($urandom), oth, ws);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule